// File: doc/BRIEF.md
# Sequenced Configuration Register Bank

This block holds ten byte-wide configuration registers, numbered 1 to 10. Together they supply a buffer's almost-empty and almost-full threshold offsets, each 10 bits wide, and a single fast-clock selection bit. Nothing in the bank is addressed explicitly over the parallel path. A write sequencer in the write-clock domain fills the registers one after another, and a read sequencer in the read-clock domain reads them back in the same order. Both sequencers start at register 1 and wrap from register 10 back to register 1. The load strobe must be active for either sequencer to move.

A separate serial port is also provided. It runs on its own serial clock, takes a short frame that carries an address and a data byte, and can write any register. It cannot read. The assembled configuration does not reach the outputs straight away. A register change appears there exactly a fixed number of write-clock cycles after the write, and an offset below the minimum legal value is raised to that minimum.

Top module: `cfgreg_file`

## Requirements
- R1: After master reset (`rstN` low), registers 4 and 7 hold 0x7F, register 10 holds 0x80 and all other registers hold 0x00. The outputs then show `aeOffset` = 127, `afOffset` = 127 and `fastClk` = 1.
- R2: A parallel write takes place on each `wclk` rising edge where `serEnN`=1, `loadN`=0 and `wrEnN`=0. It stores `wrData` into the next register in the order 1, 2, …, 10, 1, … The first write after reset goes to register 1.
- R3: A parallel read takes place on each `rclk` rising edge where `serEnN`=1, `loadN`=0 and `rdEnN`=0. On that edge `rdData` takes the next register in the same wrapping order, starting at register 1, and `rdValid` is 1 for that one cycle. `rdValid` is 0 after every other edge.
- R4: `aeOffset` is built as {reg5[1:0], reg4}, `afOffset` as {reg8[1:0], reg7}, and `fastClk` is bit 7 of register 10. All eight bits of every register are stored and read back, even bits that feed no output.
- R5: A register written on `wclk` edge k first shows on the offset and fast-clock outputs after edge k+8. After edge k+7 the outputs still show the older value.
- R6: A serial frame has 12 bits, sampled on `sclk` rising edges while `serEnN`=0 and `loadN`=1. The first 4 bits are the register address and the last 8 bits are the data, each sent MSB first. The write commits after the twelfth bit. An address outside 1 to 10 changes no register.
- R7: While `serEnN`=0 and `loadN`=0, no register changes, neither sequencer moves, no serial bit is taken and `rdValid` stays 0.
- R8: Serial writes do not move either parallel sequencer.
- R9: An assembled offset below 16 is presented as 16 on its output. Values from 16 to 1023 pass through unchanged.
- R10: Asserting master reset at any time restores the defaults, returns both sequencers to register 1 and clears any partly received serial frame.
- R11: Enable combinations with `loadN`=1 and `serEnN`=1 write no register and move neither sequencer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock; parallel writes, serial commit and output delay |
| rclk | input | 1 | Read clock for parallel read-back |
| sclk | input | 1 | Serial shift clock |
| rstN | input | 1 | Master reset, active low, asynchronous |
| loadN | input | 1 | Load strobe, active low, selects register access |
| wrEnN | input | 1 | Write enable, active low |
| rdEnN | input | 1 | Read enable, active low |
| serEnN | input | 1 | Serial select, active low |
| serIn | input | 1 | Serial data bit |
| wrData | input | 8 | Parallel write byte |
| rdData | output | 8 | Parallel read byte |
| rdValid | output | 1 | High for the cycle after a read edge |
| aeOffset | output | 10 | Effective almost-empty offset |
| afOffset | output | 10 | Effective almost-full offset |
| fastClk | output | 1 | Effective fast-clock selection bit |

## Verification
The assertions assume three things about the inputs. First, the control strobes and `wrData` are steady around each edge of the clock that samples them. Second, no read-back runs while a write or a serial commit is still settling, because the read clock reads the bank without synchronization. Third, consecutive serial frames are far enough apart in write-clock cycles for the commit toggle to cross the synchronizer. The bench follows these rules by changing inputs only on the falling edge of the clock concerned. It shifts serial bits with the select lines already held. Between phases it leaves idle gaps of twenty write-clock cycles before it reads back or compares the effective outputs.

// File: rtl/cfgreg_pkg.sv
`timescale 1ns/1ps
package cfgreg_pkg;
  localparam int NUM_REGS  = 10;
  localparam int ADDR_W    = 4;
  localparam int BYTE_W    = 8;
  localparam int OFS_W     = 10;
  localparam int HI_BITS   = OFS_W - BYTE_W;
  localparam int FRAME_W   = ADDR_W + BYTE_W;
  localparam int AE_LO     = 4;
  localparam int AE_HI     = 5;
  localparam int AF_LO     = 7;
  localparam int AF_HI     = 8;
  localparam int FAST_REG  = 10;
  localparam int FAST_BIT  = 7;

  typedef struct packed {
    logic              parWr;
    logic [ADDR_W-1:0] wrIdx;
    logic              serWr;
    logic [ADDR_W-1:0] serIdx;
    logic [BYTE_W-1:0] serData;
    logic              rdGo;
    logic [ADDR_W-1:0] rdIdx;
  } cfgStrobe_t;

  typedef struct packed {
    logic [OFS_W-1:0] ae;
    logic [OFS_W-1:0] af;
    logic             fast;
  } cfgView_t;

  function automatic logic [BYTE_W-1:0] defaultByte(input int idx);
    case (idx)
      AE_LO, AF_LO: defaultByte = 8'h7F;
      FAST_REG:     defaultByte = 8'h80;
      default:      defaultByte = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/cfgreg_ctrl.sv
`timescale 1ns/1ps
module cfgreg_ctrl
  import cfgreg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       wclk,
  input  logic       rclk,
  input  logic       sclk,
  input  logic       rstN,
  input  logic       loadN,
  input  logic       wrEnN,
  input  logic       rdEnN,
  input  logic       serEnN,
  input  logic       serIn,
  output cfgStrobe_t strb
);
  localparam logic [ADDR_W-1:0] FIRST = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] LAST  = ADDR_W'(NUM_REGS);
  localparam int CNT_W = $clog2(FRAME_W);

  // write-clock sequencer
  logic              parWrGo;
  logic [ADDR_W-1:0] wrPtr;
  assign parWrGo = serEnN && !loadN && !wrEnN;

  always_ff @(posedge wclk or negedge rstN) begin
    if (!rstN)        wrPtr <= FIRST;
    else if (parWrGo) wrPtr <= (wrPtr == LAST) ? FIRST : wrPtr + 1'b1;
  end

  // read-clock sequencer
  logic              rdGo;
  logic [ADDR_W-1:0] rdPtr;
  assign rdGo = serEnN && !loadN && !rdEnN;

  always_ff @(posedge rclk or negedge rstN) begin
    if (!rstN)     rdPtr <= FIRST;
    else if (rdGo) rdPtr <= (rdPtr == LAST) ? FIRST : rdPtr + 1'b1;
  end

  // serial shifter
  logic              serShift;
  logic [CNT_W-1:0]  bitCnt;
  logic [FRAME_W-2:0] shiftReg;
  logic [ADDR_W-1:0] frameAddr;
  logic [BYTE_W-1:0] frameData;
  logic              frameTgl;
  assign serShift = !serEnN && loadN;

  always_ff @(posedge sclk or negedge rstN) begin
    if (!rstN) begin
      bitCnt    <= '0;
      shiftReg  <= '0;
      frameAddr <= '0;
      frameData <= '0;
      frameTgl  <= 1'b0;
    end else if (serShift) begin
      if (bitCnt == CNT_W'(FRAME_W - 1)) begin
        frameAddr <= shiftReg[FRAME_W-2 -: ADDR_W];
        frameData <= {shiftReg[BYTE_W-2:0], serIn};
        frameTgl  <= ~frameTgl;
        bitCnt    <= '0;
      end else begin
        shiftReg <= {shiftReg[FRAME_W-3:0], serIn};
        bitCnt   <= bitCnt + 1'b1;
      end
    end
  end

  // commit toggle into the write-clock domain
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   tglSeen;
  logic                   addrOk;
  always_ff @(posedge wclk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= '0;
      tglSeen <= 1'b0;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-2:0], frameTgl};
      tglSeen <= syncQ[SYNC_STAGES-1];
    end
  end
  assign addrOk = (frameAddr >= FIRST) && (frameAddr <= LAST);

  always_comb begin
    strb         = '0;
    strb.parWr   = parWrGo;
    strb.wrIdx   = wrPtr;
    strb.serWr   = (syncQ[SYNC_STAGES-1] ^ tglSeen) && addrOk;
    strb.serIdx  = frameAddr;
    strb.serData = frameData;
    strb.rdGo    = rdGo;
    strb.rdIdx   = rdPtr;
  end

  AST_WR_WRAP: assert property (@(posedge wclk) disable iff (!rstN)
    (parWrGo && wrPtr == LAST) |=> (wrPtr == FIRST)); // R2
  AST_WR_STEP: assert property (@(posedge wclk) disable iff (!rstN)
    (parWrGo && wrPtr != LAST) |=> (wrPtr == $past(wrPtr) + 1'b1)); // R2
  AST_RD_WRAP: assert property (@(posedge rclk) disable iff (!rstN)
    (rdGo && rdPtr == LAST) |=> (rdPtr == FIRST)); // R3
  AST_ILLEGAL_WPTR: assert property (@(posedge wclk) disable iff (!rstN)
    (!serEnN && !loadN) |=> $stable(wrPtr)); // R7
  AST_ILLEGAL_SHIFT: assert property (@(posedge sclk) disable iff (!rstN)
    (!serEnN && !loadN) |=> $stable(bitCnt)); // R7
endmodule

// File: rtl/cfgreg_data.sv
`timescale 1ns/1ps
module cfgreg_data
  import cfgreg_pkg::*;
#(
  parameter int EFFECT_DELAY = 8,
  parameter int MIN_OFS      = 16
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rstN,
  input  cfgStrobe_t        strb,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rdData,
  output logic              rdValid,
  output cfgView_t          view
);
  localparam logic [OFS_W-1:0] FLOOR = OFS_W'(MIN_OFS);

  logic [NUM_REGS:1][BYTE_W-1:0] bank, bankNext, bankInit;

  for (genvar g = 1; g <= NUM_REGS; g++) begin : g_reg
    assign bankInit[g] = defaultByte(g);
    always_comb begin
      if (strb.parWr && strb.wrIdx == ADDR_W'(g))       bankNext[g] = wrData;
      else if (strb.serWr && strb.serIdx == ADDR_W'(g)) bankNext[g] = strb.serData;
      else                                              bankNext[g] = bank[g];
    end
  end

  always_ff @(posedge wclk or negedge rstN) begin
    if (!rstN) bank <= bankInit;
    else       bank <= bankNext;
  end

  // read-back port
  always_ff @(posedge rclk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strb.rdGo;
      if (strb.rdGo) rdData <= bank[strb.rdIdx];
    end
  end

  // assemble and floor
  logic [OFS_W-1:0] aeRaw, afRaw;
  cfgView_t         live, initView;
  assign aeRaw = {bank[AE_HI][HI_BITS-1:0], bank[AE_LO]};
  assign afRaw = {bank[AF_HI][HI_BITS-1:0], bank[AF_LO]};
  always_comb begin
    live.ae   = (aeRaw < FLOOR) ? FLOOR : aeRaw;
    live.af   = (afRaw < FLOOR) ? FLOOR : afRaw;
    live.fast = bank[FAST_REG][FAST_BIT];
    initView.ae   = {bankInit[AE_HI][HI_BITS-1:0], bankInit[AE_LO]};
    initView.af   = {bankInit[AF_HI][HI_BITS-1:0], bankInit[AF_LO]};
    initView.fast = bankInit[FAST_REG][FAST_BIT];
  end

  // effect delay line
  cfgView_t pipe [EFFECT_DELAY];
  always_ff @(posedge wclk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < EFFECT_DELAY; s++) pipe[s] <= initView;
    end else begin
      pipe[0] <= live;
      for (int s = 1; s < EFFECT_DELAY; s++) pipe[s] <= pipe[s-1];
    end
  end
  assign view = pipe[EFFECT_DELAY-1];

  AST_BANK_HOLD: assert property (@(posedge wclk) disable iff (!rstN)
    (!strb.parWr && !strb.serWr) |=> $stable(bank)); // R11
  AST_OFFSET_FLOOR: assert property (@(posedge wclk) disable iff (!rstN)
    (view.ae >= FLOOR) && (view.af >= FLOOR)); // R9
  AST_READ_PULSE: assert property (@(posedge rclk) disable iff (!rstN)
    !strb.rdGo |=> !rdValid); // R3
endmodule

// File: rtl/cfgreg_file.sv
`timescale 1ns/1ps
module cfgreg_file
  import cfgreg_pkg::*;
#(
  parameter int EFFECT_DELAY = 8,
  parameter int SYNC_STAGES  = 2,
  parameter int MIN_OFS      = 16
) (
  input  logic             wclk,
  input  logic             rclk,
  input  logic             sclk,
  input  logic             rstN,
  input  logic             loadN,
  input  logic             wrEnN,
  input  logic             rdEnN,
  input  logic             serEnN,
  input  logic             serIn,
  input  logic [7:0]       wrData,
  output logic [7:0]       rdData,
  output logic             rdValid,
  output logic [9:0]       aeOffset,
  output logic [9:0]       afOffset,
  output logic             fastClk
);
  cfgStrobe_t strb;
  cfgView_t   view;

  cfgreg_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .wclk(wclk), .rclk(rclk), .sclk(sclk), .rstN(rstN),
    .loadN(loadN), .wrEnN(wrEnN), .rdEnN(rdEnN),
    .serEnN(serEnN), .serIn(serIn), .strb(strb)
  );

  cfgreg_data #(.EFFECT_DELAY(EFFECT_DELAY), .MIN_OFS(MIN_OFS)) u_data (
    .wclk(wclk), .rclk(rclk), .rstN(rstN), .strb(strb),
    .wrData(wrData), .rdData(rdData), .rdValid(rdValid), .view(view)
  );

  assign aeOffset = view.ae;
  assign afOffset = view.af;
  assign fastClk  = view.fast;
endmodule

// File: tb/tb_cfgreg_file.sv
`timescale 1ns/1ps
module tb_cfgreg_file;
  logic wclk = 0, rclk = 0, sclk = 0;
  logic rstN = 0, loadN = 1, wrEnN = 1, rdEnN = 1, serEnN = 1, serIn = 0;
  logic [7:0] wrData = 0;
  logic [7:0] rdData;
  logic rdValid;
  logic [9:0] aeOffset, afOffset;
  logic fastClk;

  always #2.5 wclk = ~wclk;
  always #3.5 rclk = ~rclk;

  cfgreg_file dut (
    .wclk(wclk), .rclk(rclk), .sclk(sclk), .rstN(rstN), .loadN(loadN),
    .wrEnN(wrEnN), .rdEnN(rdEnN), .serEnN(serEnN), .serIn(serIn),
    .wrData(wrData), .rdData(rdData), .rdValid(rdValid),
    .aeOffset(aeOffset), .afOffset(afOffset), .fastClk(fastClk)
  );

  int nVec = 0, nBad = 0;
  logic [7:0] model [1:10];
  int mWr = 1, mRd = 1;
  logic [7:0] expQ [$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int i = 1; i <= 10; i++) model[i] = 8'h00;
    model[4] = 8'h7F; model[7] = 8'h7F; model[10] = 8'h80;
    mWr = 1; mRd = 1;
  endtask

  function automatic logic [9:0] floorOfs(input logic [9:0] v);
    return (v < 10'd16) ? 10'd16 : v;
  endfunction

  task automatic chkView(input string req);
    chk({req, " aeOffset"}, 32'(aeOffset), 32'(floorOfs({model[5][1:0], model[4]})));
    chk({req, " afOffset"}, 32'(afOffset), 32'(floorOfs({model[8][1:0], model[7]})));
    chk({req, " fastClk"}, 32'(fastClk), 32'(model[10][7]));
  endtask

  task automatic settle();
    repeat (20) @(negedge wclk);
  endtask

  task automatic parWrite(input logic [7:0] d);
    @(negedge wclk);
    loadN = 0; wrEnN = 0; wrData = d;
    model[mWr] = d;
    mWr = (mWr == 10) ? 1 : mWr + 1;
  endtask

  task automatic parIdle();
    @(negedge wclk);
    wrEnN = 1; loadN = 1;
  endtask

  task automatic parRead(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge rclk);
      loadN = 0; rdEnN = 0;
      expQ.push_back(model[mRd]);
      mRd = (mRd == 10) ? 1 : mRd + 1;
    end
    @(negedge rclk);
    rdEnN = 1; loadN = 1;
    repeat (3) @(negedge rclk);
    chk("R3 read queue drained", 32'(expQ.size()), 32'd0);
  endtask

  task automatic serialFrame(input logic [3:0] a, input logic [7:0] d);
    logic [11:0] fr;
    fr = {a, d};
    for (int i = 11; i >= 0; i--) begin
      serIn = fr[i];
      #4 sclk = 1;
      #4 sclk = 0;
    end
  endtask

  task automatic serialWrite(input logic [3:0] a, input logic [7:0] d);
    serEnN = 0; loadN = 1;
    #4;
    serialFrame(a, d);
    #4 serEnN = 1;
    if (a >= 1 && a <= 10) model[a] = d;
    settle();
  endtask

  // scoreboard monitor
  always @(negedge rclk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) begin
        nVec++; nBad++;
        $display("FAIL R3/R7/R11 unexpected read actual=%0h expected=none", rdData);
      end else begin
        chk("R3 read data", 32'(rdData), 32'(expQ.pop_front()));
      end
    end
  end

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  endtask

  initial begin
    #150000;
    nVec++; nBad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    modelReset();
    repeat (5) @(negedge wclk);
    rstN = 1;
    settle();
    // R1 reset state
    chkView("R1 reset");
    parRead(10);

    // R2 R4: full write sequence, R3 wrap on read
    parWrite(8'hA1); parWrite(8'hB2); parWrite(8'hC3); parWrite(8'h34);
    parWrite(8'h02); parWrite(8'h66); parWrite(8'h9C); parWrite(8'hFD);
    parWrite(8'h09); parWrite(8'h00);
    parIdle(); settle();
    chkView("R4 assembled");
    parRead(12);
    // R2 wrap to register 1
    parWrite(8'h5A); parWrite(8'hA5);
    parIdle(); settle();
    parRead(10);

    // R5 effect delay: write reg3 then reg4 (edge k)
    parWrite(8'h00); parWrite(8'h40);
    parIdle();
    repeat (7) @(negedge wclk);
    chk("R5 before delay aeOffset", 32'(aeOffset), 32'd564);
    @(negedge wclk);
    chk("R5 after delay aeOffset", 32'(aeOffset), 32'd576);
    settle();

    // R9 floor: reg5=0, reg6, reg7=5, reg8=0
    parWrite(8'h00); parWrite(8'h77); parWrite(8'h05); parWrite(8'h00);
    parIdle(); settle();
    chkView("R9 floor");
    chk("R9 afOffset 16", 32'(afOffset), 32'd16);

    // R6 serial writes, R9 boundary
    serialWrite(4'h7, 8'h10);
    chk("R9 af at 16", 32'(afOffset), 32'd16);
    serialWrite(4'h7, 8'h11);
    chk("R9 af at 17", 32'(afOffset), 32'd17);
    serialWrite(4'h7, 8'h0F);
    chkView("R6 serial reg7");
    serialWrite(4'hA, 8'h80);
    chk("R6 fastClk serial", 32'(fastClk), 32'd1);
    serialWrite(4'h5, 8'hFF);
    chkView("R6 serial reg5");
    serialWrite(4'h0, 8'hFF);
    serialWrite(4'hB, 8'hEE);
    serialWrite(4'hF, 8'hEE);
    parRead(10);
    // R8 sequencers untouched by serial
    parWrite(8'h3C);
    parIdle(); settle();
    parRead(10);

    // R7 illegal combination
    serEnN = 0; loadN = 0; wrEnN = 0; rdEnN = 0; wrData = 8'hEE;
    #4;
    serialFrame(4'h4, 8'hEE);
    settle();
    serEnN = 1; loadN = 1; wrEnN = 1; rdEnN = 1;
    settle();
    chkView("R7 illegal");
    parRead(10);
    serialWrite(4'h2, 8'h42);
    parRead(10);

    // R11 loadN high
    wrEnN = 0; rdEnN = 0; wrData = 8'hDD;
    settle();
    wrEnN = 1; rdEnN = 1;
    settle();
    chkView("R11 load high");
    parWrite(8'h81);
    parIdle(); settle();
    parRead(10);

    // R10 reset mid-burst, with partial serial frame
    serEnN = 0; #4;
    for (int i = 0; i < 5; i++) begin serIn = 1; #4 sclk = 1; #4 sclk = 0; end
    serEnN = 1;
    parWrite(8'h12); parWrite(8'h13);
    @(negedge wclk);
    rstN = 0;
    wrEnN = 1; loadN = 1;
    #1;
    modelReset();
    chkView("R10 reset outputs");
    repeat (3) @(negedge wclk);
    rstN = 1;
    settle();
    parRead(10);
    serialWrite(4'h8, 8'h01);
    chkView("R10 serial frame realigned");
    parWrite(8'h20);
    parIdle(); settle();
    chkView("R10 write to register 1");
    parRead(10);

    finishRun();
  end
endmodule